// File: doc/BRIEF.md
# Cascadable Parallel-Load Input Serializer

This block takes a word of already-filtered input channel states and sends it to a controller one bit at a time. The register is loaded with all channels together while the load control is held low. Once load is released, each rising edge of the serial clock moves the word one place toward the serial output, highest channel first. Shifting happens only while the active-low clock-enable is held low.

The serial input feeds the lowest position as bits move up. Wiring one block's serial output to the next block's serial input builds a longer chain, so a controller can read several input groups through one pin. While load is low, the serial output shows the top parallel input straight away, without waiting for a clock edge. The first bit is therefore ready before the first shift.

The serial path is a plain bit stream paced by the clock and the enable. It has no valid/ready handshake. The enable is the only way to hold the stream, and the controller owns it.

Top module: `pisu_chain_ser`

## Requirements
- R1: While `rst_n` is low, the register is cleared. With load inactive (`ld_n` high) after reset, `sout` reads 0.
- R2: At each `clk` rising edge where `ld_n` is low, every register bit i takes `par_in[i]`.
- R3: While `ld_n` is low, `sout` equals `par_in[WIDTH-1]` at once, with no clock edge needed, and it follows changes on that input.
- R4: At a `clk` rising edge with `ld_n` high and `ce_n` low, bit i takes bit i-1 and bit 0 takes `sin`. With `ld_n` high, `sout` shows bit WIDTH-1. A loaded word therefore leaves highest channel first, one bit per edge.
- R5: At a `clk` rising edge with `ld_n` high and `ce_n` high, the register keeps its value and `sout` does not change.
- R6: A low `ld_n` wins over a low `ce_n`. The edge loads and does not shift.
- R7: When the upstream block's `sout` drives the downstream block's `sin`, and both load at the same time, the downstream `sout` gives the downstream word (highest bit first), then the upstream word (highest bit first).
- R8: After a whole word has left, further shifts present on `sout` the bits that entered on `sin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial shift clock; rising edge active |
| rst_n | input | 1 | Asynchronous active-low clear |
| ld_n | input | 1 | Active-low parallel load |
| ce_n | input | 1 | Active-low shift enable |
| sin | input | 1 | Chain input from the upstream block |
| par_in | input | WIDTH | Filtered channel states |
| sout | output | 1 | Serial output, highest channel first |

## Verification
The clocked properties assume that `ld_n`, `ce_n`, `sin` and `par_in` are steady around each rising `clk` edge. In particular, the load must be released, and the enable set up, well before the edge they are meant to affect. The bench changes every input only on the falling edge, half a period away from any sampling edge. This matches the required recovery gap after load and the required enable setup time. The load-to-output path is combinational. The bench checks it a short delay after driving `ld_n` or `par_in`, with no clock edge in between.

// File: rtl/pisu_pkg.sv
package pisu_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2
  } pisu_op_e;
endpackage

// File: rtl/pisu_ctrl.sv
module pisu_ctrl
  import pisu_pkg::*;
(
  input  logic     ld_n,
  input  logic     ce_n,
  output pisu_op_e op
);
  // Load has priority over the shift enable
  always_comb begin
    if (!ld_n)      op = OP_LOAD;
    else if (!ce_n) op = OP_SHIFT;
    else            op = OP_HOLD;
  end
endmodule

// File: rtl/pisu_cell.sv
module pisu_cell
  import pisu_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pisu_op_e op,
  input  logic     par_d,
  input  logic     chain_d,
  output logic     q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else begin
      unique case (op)
        OP_LOAD:  q <= par_d;
        OP_SHIFT: q <= chain_d;
        default:  q <= q;
      endcase
    end
  end
endmodule

// File: rtl/pisu_tap.sv
module pisu_tap
  import pisu_pkg::*;
(
  input  pisu_op_e op,
  input  logic     par_top,
  input  logic     reg_top,
  output logic     sout
);
  // Combinational bypass during load so the first bit is ready at once
  always_comb sout = (op == OP_LOAD) ? par_top : reg_top;
endmodule

// File: rtl/pisu_chain_ser.sv
module pisu_chain_ser
  import pisu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_n,
  input  logic             ce_n,
  input  logic             sin,
  input  logic [WIDTH-1:0] par_in,
  output logic             sout
);
  localparam int TOP = WIDTH - 1;

  pisu_op_e         op;
  logic [WIDTH-1:0] q;

  pisu_ctrl u_ctrl (
    .ld_n (ld_n),
    .ce_n (ce_n),
    .op   (op)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic chain_d;
    if (i == 0) begin : g_head
      assign chain_d = sin;
    end else begin : g_body
      assign chain_d = q[i-1];
    end
    pisu_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .op      (op),
      .par_d   (par_in[i]),
      .chain_d (chain_d),
      .q       (q[i])
    );
  end

  pisu_tap u_tap (
    .op      (op),
    .par_top (par_in[TOP]),
    .reg_top (q[TOP]),
    .sout    (sout)
  );

  // Load captures the whole word
  assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_n |=> q == $past(par_in));

  // Output follows the top parallel input during load
  assert_load_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_n |-> sout == par_in[TOP]);

  // Output reflects the top register bit outside load
  assert_tap_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_n |-> sout == q[TOP]);

  // Enabled shift moves the word up and takes in the chain bit
  assert_shift_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_n && !ce_n) |=> q == WIDTH'({$past(q), $past(sin)}));

  // Disabled clock leaves the register alone
  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_n && ce_n) |=> $stable(q));

  // Load wins over an active enable
  assert_load_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_n && !ce_n) |=> q == $past(par_in));
endmodule

// File: tb/sim_pisu_chain_ser.sv
module sim_pisu_chain_ser;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ld_n = 1'b1;
  logic         ce_n = 1'b1;
  logic         chain_in = 1'b0;
  logic [W-1:0] par0 = '0;
  logic [W-1:0] par1 = '0;
  logic         sout0, sout1;
  int           nvec = 0;
  int           nbad = 0;

  always #5 clk = ~clk;

  // u0 is upstream; its serial output feeds u1
  pisu_chain_ser #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .ce_n(ce_n),
    .sin(chain_in), .par_in(par0), .sout(sout0));
  pisu_chain_ser #(.WIDTH(W)) u1 (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .ce_n(ce_n),
    .sin(sout0), .par_in(par1), .sout(sout1));

  task automatic check(input string req, input logic got, input logic exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();
    check("R1 reset sout0", sout0, 1'b0);
    check("R1 reset sout1", sout1, 1'b0);
  endtask

  task automatic t_bypass();
    par0 = 8'hA5;
    ld_n = 1'b0;
    #1 check("R3 immediate top bit", sout0, 1'b1);
    par0 = 8'h25;
    #1 check("R3 follows input", sout0, 1'b0);
    @(negedge clk);
    ld_n = 1'b1;
  endtask

  task automatic t_shift_order(input logic [W-1:0] pat);
    par0 = pat;
    ld_n = 1'b0;
    tick();
    ld_n = 1'b1;
    ce_n = 1'b0;
    chain_in = 1'b0;
    #1 check("R2 loaded top bit", sout0, pat[W-1]);
    for (int i = W - 1; i >= 0; i--) begin
      check("R4 shift order", sout0, pat[i]);
      tick();
    end
    ce_n = 1'b1;
  endtask

  task automatic t_hold();
    par0 = 8'h6B;
    ld_n = 1'b0;
    tick();
    ld_n = 1'b1;
    ce_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R5 held top bit", sout0, 1'b0);
    end
    ce_n = 1'b0;
    tick();
    check("R5 resume after hold", sout0, 1'b1);
    tick();
    check("R5 resume second bit", sout0, 1'b1);
    ce_n = 1'b1;
  endtask

  task automatic t_priority();
    par0 = 8'h00;
    ce_n = 1'b0;
    ld_n = 1'b0;
    tick();
    par0 = 8'h80;
    tick();
    ld_n = 1'b1;
    ce_n = 1'b1;
    #1 check("R6 load beats enable", sout0, 1'b1);
    ce_n = 1'b0;
    tick();
    check("R6 next bit after load", sout0, 1'b0);
    ce_n = 1'b1;
  endtask

  task automatic t_chain();
    logic [W-1:0] a = 8'h3C;
    logic [W-1:0] b = 8'hC9;
    par0 = a;
    par1 = b;
    ld_n = 1'b0;
    tick();
    ld_n = 1'b1;
    ce_n = 1'b0;
    chain_in = 1'b1;
    for (int k = 0; k < 2 * W; k++) begin
      logic e;
      e = (k < W) ? b[W-1-k] : a[2*W-1-k];
      check("R7 chained order", sout1, e);
      tick();
    end
    check("R8 fill from sin", sout1, 1'b1);
    tick();
    check("R8 fill from sin", sout1, 1'b1);
    ce_n = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_bypass();
    t_shift_order(8'hA5);
    t_shift_order(8'h5A);
    t_shift_order(8'h81);
    t_hold();
    t_priority();
    t_chain();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #200000;
    nvec++;
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule